// File: doc/BRIEF.md
# PCI Slot Hotplug Event Controller

This block keeps three slot bitmaps for a single PCI bus: which slots hold a device, which slots allow hotplug, and which slots have an unplug request that is waiting for an eject. Software reads and writes a 16-byte register window with 32-bit accesses. Plug, unplug and power-up (cold) presence events arrive on a side-band port that carries a slot number. Each hotplug event sets bit 1 of a small general-purpose event block. That block has a status half and an enable half, and it drives the SCI interrupt line.

The "slots up" register is not stored. It is formed on every read as present AND hotplug-enabled, so each populated hotpluggable slot asks for a device check. An eject write acts on one slot only: the lowest set bit of the data. A platform reset does not throw pending removals away. It first ejects them one per cycle, lowest slot first, and then rebuilds the hotplug-enable and present maps from the live inputs.

Top module: `hp_slot_ctrl`

## Requirements
- R1: Window map, all 32-bit little-endian. Offset 0x4 returns the pending-removal bitmap, 0x0 returns "slots up", 0x8 is the eject register and 0xC returns the hotplug-enable bitmap. Bit n stands for slot n. Any other offset reads zero.
- R2: A read of offset 0x0 returns present AND hotplug-enable.
- R3: A read of offset 0x8 always returns zero.
- R4: A 4-byte write to offset 0x8 picks the slot at the lowest set bit of the data and clears that slot's pending bit. It also clears the slot's present bit, unless the live non-hotpluggable mask marks that slot. Write data of zero changes nothing.
- R5: A plug event (kind 1) for slot n sets present bit n and event status bit 1 in the next cycle.
- R6: An unplug event (kind 2) for slot n sets pending bit n and event status bit 1. Present bit n stays set.
- R7: A cold event (kind 0) sets present bit n and leaves the event status unchanged. Kind 3 means no event.
- R8: After hardware reset, and at the end of a platform reset, the pending bitmap is empty. Hotplug-enable equals the inverse of the non-hotpluggable mask, and present equals the populated input.
- R9: A window access whose byte count is not 4 is ignored. Such a read returns zero and such a write changes no state.
- R10: A platform reset pulse drops `ready` for exactly popcount(pending)+2 cycles, ejecting one pending slot per cycle. Events and eject writes arriving while `ready` is low are ignored.
- R11: `sci` is high exactly when some event status bit and its matching enable bit are both set.
- R12: Event bytes 0-1 are status and bytes 2-3 are enable. Writing 1 to a status bit clears it and writing 0 leaves it alone. Enable bytes are written as data and read back. A hotplug event in the same cycle as a clear of status bit 1 leaves the bit set.
- R13: An unplug event and an eject of the same slot in the same cycle leave that slot's pending bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| plat_rst | input | 1 | Platform reset pulse; starts the removal flush and rebuild |
| acc_valid | input | 1 | Window access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 4 | Window byte offset |
| acc_bytes | input | 3 | Access size in bytes |
| acc_wdata | input | 32 | Window write data |
| acc_rdata | output | 32 | Window read data (combinational) |
| gpe_valid | input | 1 | Event block byte access strobe |
| gpe_write | input | 1 | 1 = write, 0 = read |
| gpe_addr | input | 2 | Event block byte offset |
| gpe_wdata | input | 8 | Event block write data |
| gpe_rdata | output | 8 | Event block read data (combinational) |
| ev_kind | input | 2 | 0 cold, 1 plug, 2 unplug, 3 none |
| ev_slot | input | 5 | Slot number of the event |
| nohp_mask | input | 32 | Slots holding non-hotpluggable devices |
| populated | input | 32 | Slots populated, sampled at rebuild |
| ready | output | 1 | High when idle and accepting events |
| sci | output | 1 | System control interrupt |

## Verification
A wrong bit in the present or hotplug-enable map shows on the next 0x0 read, one cycle after the event that caused it. A wrong pending bit shows on the next 0x4 read, and a leftover pending bit survives a platform reset only if the flush is broken. A broken flush also shows at the port as a wrong number of `ready`-low cycles, because the length of that window depends on how many removals were pending. Event status faults reach `sci` in the cycle after the set or clear, as soon as the matching enable bit is on.

// File: rtl/hp_pkg.sv
package hp_pkg;
  typedef enum logic [1:0] {
    EV_COLD   = 2'd0,
    EV_PLUG   = 2'd1,
    EV_UNPLUG = 2'd2,
    EV_NONE   = 2'd3
  } hp_ev_e;

  typedef enum logic [1:0] {
    ST_REBUILD = 2'd0,
    ST_IDLE    = 2'd1,
    ST_FLUSH   = 2'd2
  } hp_state_e;

  localparam int unsigned WIN_DW = 32;
  localparam int unsigned WIN_AW = 4;
  localparam logic [WIN_AW-1:0] OFS_UP    = 4'h0;
  localparam logic [WIN_AW-1:0] OFS_DOWN  = 4'h4;
  localparam logic [WIN_AW-1:0] OFS_EJECT = 4'h8;
  localparam logic [WIN_AW-1:0] OFS_RMV   = 4'hC;
  localparam logic [2:0]        ACC_WORD  = 3'd4;
endpackage

// File: rtl/hp_lowest_one.sv
module hp_lowest_one #(
  parameter int W = 32
) (
  input  logic [W-1:0] vec,
  output logic [W-1:0] onehot
);
  logic [W:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_scan
    assign onehot[i]  = vec[i] & ~seen[i];
    assign seen[i+1]  = seen[i] | vec[i];
  end
endmodule

// File: rtl/hp_gpe_block.sv
module hp_gpe_block #(
  parameter  int GPE_BYTES = 2,
  parameter  int HP_BIT    = 1,
  localparam int GW        = 8 * GPE_BYTES,
  localparam int GAW       = $clog2(2 * GPE_BYTES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           gpe_valid,
  input  logic           gpe_write,
  input  logic [GAW-1:0] gpe_addr,
  input  logic [7:0]     gpe_wdata,
  input  logic           hp_set,
  output logic [7:0]     gpe_rdata,
  output logic           sci
);
  logic [GW-1:0] sts_q, sts_d;
  logic [GW-1:0] en_q,  en_d;
  logic          wr_en;
  int unsigned   ai;

  assign wr_en = gpe_valid & gpe_write;
  assign ai    = 32'(gpe_addr);

  always_comb begin
    sts_d = sts_q;
    en_d  = en_q;
    for (int b = 0; b < GPE_BYTES; b++) begin
      if (wr_en && ai == 32'(b))
        sts_d[8*b +: 8] = sts_q[8*b +: 8] & ~gpe_wdata;
      if (wr_en && ai == 32'(b + GPE_BYTES))
        en_d[8*b +: 8] = gpe_wdata;
    end
    if (hp_set) sts_d[HP_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= sts_d;
      en_q  <= en_d;
    end
  end

  always_comb begin
    gpe_rdata = 8'h00;
    if (gpe_valid && !gpe_write) begin
      if (ai < 32'(GPE_BYTES))
        gpe_rdata = sts_q[8*ai +: 8];
      else if (ai < 32'(2 * GPE_BYTES))
        gpe_rdata = en_q[8*(ai - 32'(GPE_BYTES)) +: 8];
    end
  end

  assign sci = |(sts_q & en_q);

  // R5: a hotplug event leaves the status bit set in the next cycle
  a_r5_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
    hp_set |=> sts_q[HP_BIT]);

  // R12: a status clear with no colliding event removes the written ones
  a_r12_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && gpe_addr == '0 && !hp_set) |=> ((sts_q[7:0] & $past(gpe_wdata)) == 8'h00));

  // R11: no interrupt without any enable bit
  a_r11_sci_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !sci);
endmodule

// File: rtl/hp_slot_maps.sv
module hp_slot_maps
  import hp_pkg::*;
#(
  parameter  int NSLOTS = 32,
  localparam int SW     = $clog2(NSLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              plat_rst,
  input  hp_ev_e            ev_kind,
  input  logic [SW-1:0]     ev_slot,
  input  logic [NSLOTS-1:0] nohp_mask,
  input  logic [NSLOTS-1:0] populated,
  input  logic              eject_fire,
  input  logic [NSLOTS-1:0] eject_sel,
  output logic [NSLOTS-1:0] present_q,
  output logic [NSLOTS-1:0] down_q,
  output logic [NSLOTS-1:0] hpen_q,
  output logic              ready,
  output logic              hp_event
);
  hp_state_e         state_q, state_d;
  logic [NSLOTS-1:0] present_d, down_d, hpen_d;
  logic [NSLOTS-1:0] slot_oh;
  logic [NSLOTS-1:0] flush_oh;

  assign slot_oh = NSLOTS'(1) << ev_slot;

  hp_lowest_one #(.W(NSLOTS)) u_flush_pick (
    .vec    (down_q),
    .onehot (flush_oh)
  );

  always_comb begin
    state_d   = state_q;
    present_d = present_q;
    down_d    = down_q;
    hpen_d    = hpen_q;
    hp_event  = 1'b0;
    unique case (state_q)
      ST_REBUILD: begin
        hpen_d    = ~nohp_mask;
        present_d = populated;
        down_d    = '0;
        state_d   = plat_rst ? ST_FLUSH : ST_IDLE;
      end
      ST_FLUSH: begin
        if (down_q == '0) begin
          state_d = ST_REBUILD;
        end else begin
          down_d    = down_q & ~flush_oh;
          present_d = present_q & ~(flush_oh & ~nohp_mask);
        end
      end
      ST_IDLE: begin
        if (plat_rst) begin
          state_d = ST_FLUSH;
        end else begin
          if (eject_fire) begin
            down_d    = down_d & ~eject_sel;
            present_d = present_d & ~(eject_sel & ~nohp_mask);
          end
          unique case (ev_kind)
            EV_COLD:   present_d = present_d | slot_oh;
            EV_PLUG: begin
              present_d = present_d | slot_oh;
              hp_event  = 1'b1;
            end
            EV_UNPLUG: begin
              down_d   = down_d | slot_oh;
              hp_event = 1'b1;
            end
            default: ;
          endcase
        end
      end
      default: state_d = ST_REBUILD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_REBUILD;
      present_q <= '0;
      down_q    <= '0;
      hpen_q    <= '0;
    end else begin
      state_q   <= state_d;
      present_q <= present_d;
      down_q    <= down_d;
      hpen_q    <= hpen_d;
    end
  end

  assign ready = (state_q == ST_IDLE);

  // R6: an unplug request never clears the present bit of its slot
  a_r6_unplug_keeps_present: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !plat_rst && ev_kind == EV_UNPLUG && !eject_fire && present_q[ev_slot])
      |=> present_q[$past(ev_slot)]);

  // R10: each flush cycle with work retires exactly one pending slot
  a_r10_flush_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FLUSH && down_q != '0)
      |=> ($countones(down_q) + 1 == $past($countones(down_q))));

  // R8: rebuild leaves no pending removal and reloads the enable map
  a_r8_rebuild_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REBUILD) |=> (down_q == '0 && hpen_q == ~$past(nohp_mask)));
endmodule

// File: rtl/hp_reg_window.sv
module hp_reg_window
  import hp_pkg::*;
#(
  parameter int NSLOTS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [WIN_AW-1:0] acc_addr,
  input  logic [2:0]        acc_bytes,
  input  logic [WIN_DW-1:0] acc_wdata,
  input  logic [NSLOTS-1:0] present_q,
  input  logic [NSLOTS-1:0] down_q,
  input  logic [NSLOTS-1:0] hpen_q,
  input  logic              ready,
  output logic [WIN_DW-1:0] acc_rdata,
  output logic              eject_fire,
  output logic [NSLOTS-1:0] eject_sel
);
  logic              word_ok;
  logic [NSLOTS-1:0] wslots;

  assign word_ok = acc_valid && (acc_bytes == ACC_WORD);
  assign wslots  = acc_wdata[NSLOTS-1:0];

  hp_lowest_one #(.W(NSLOTS)) u_eject_pick (
    .vec    (wslots),
    .onehot (eject_sel)
  );

  assign eject_fire = word_ok && acc_write && (acc_addr == OFS_EJECT)
                    && ready && (wslots != '0);

  always_comb begin
    acc_rdata = '0;
    if (word_ok && !acc_write) begin
      unique case (acc_addr)
        OFS_UP:   acc_rdata[NSLOTS-1:0] = present_q & hpen_q;
        OFS_DOWN: acc_rdata[NSLOTS-1:0] = down_q;
        OFS_RMV:  acc_rdata[NSLOTS-1:0] = hpen_q;
        default:  acc_rdata = '0;
      endcase
    end
  end

  // R4: an eject always names exactly one slot
  a_r4_eject_single: assert property (@(posedge clk) disable iff (!rst_n)
    eject_fire |-> ($countones(eject_sel) == 1));

  // R9: a narrow access never triggers an eject
  a_r9_narrow_no_eject: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_bytes != ACC_WORD) |-> !eject_fire);
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_pkg::*;
#(
  parameter  int NSLOTS    = 32,
  parameter  int GPE_BYTES = 2,
  parameter  int HP_BIT    = 1,
  localparam int SW        = $clog2(NSLOTS),
  localparam int GAW       = $clog2(2 * GPE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              plat_rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [3:0]        acc_addr,
  input  logic [2:0]        acc_bytes,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       acc_rdata,
  input  logic              gpe_valid,
  input  logic              gpe_write,
  input  logic [GAW-1:0]    gpe_addr,
  input  logic [7:0]        gpe_wdata,
  output logic [7:0]        gpe_rdata,
  input  logic [1:0]        ev_kind,
  input  logic [SW-1:0]     ev_slot,
  input  logic [NSLOTS-1:0] nohp_mask,
  input  logic [NSLOTS-1:0] populated,
  output logic              ready,
  output logic              sci
);
  logic [NSLOTS-1:0] present_q, down_q, hpen_q, eject_sel;
  logic              eject_fire, hp_event;

  hp_slot_maps #(.NSLOTS(NSLOTS)) u_maps (
    .clk        (clk),
    .rst_n      (rst_n),
    .plat_rst   (plat_rst),
    .ev_kind    (hp_ev_e'(ev_kind)),
    .ev_slot    (ev_slot),
    .nohp_mask  (nohp_mask),
    .populated  (populated),
    .eject_fire (eject_fire),
    .eject_sel  (eject_sel),
    .present_q  (present_q),
    .down_q     (down_q),
    .hpen_q     (hpen_q),
    .ready      (ready),
    .hp_event   (hp_event)
  );

  hp_reg_window #(.NSLOTS(NSLOTS)) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_addr   (acc_addr),
    .acc_bytes  (acc_bytes),
    .acc_wdata  (acc_wdata),
    .present_q  (present_q),
    .down_q     (down_q),
    .hpen_q     (hpen_q),
    .ready      (ready),
    .acc_rdata  (acc_rdata),
    .eject_fire (eject_fire),
    .eject_sel  (eject_sel)
  );

  hp_gpe_block #(.GPE_BYTES(GPE_BYTES), .HP_BIT(HP_BIT)) u_gpe (
    .clk       (clk),
    .rst_n     (rst_n),
    .gpe_valid (gpe_valid),
    .gpe_write (gpe_write),
    .gpe_addr  (gpe_addr),
    .gpe_wdata (gpe_wdata),
    .hp_set    (hp_event),
    .gpe_rdata (gpe_rdata),
    .sci       (sci)
  );
endmodule

// File: tb/sim_hp_slot_ctrl.sv
module sim_hp_slot_ctrl;
  localparam logic [3:0] OP_COLD = 4'd0, OP_PLUG = 4'd1, OP_UNPLUG = 4'd2,
                         OP_WWR = 4'd3, OP_WRD = 4'd4, OP_GWR = 4'd5,
                         OP_GRD = 4'd6, OP_SCI = 4'd7, OP_WWR_N = 4'd8,
                         OP_WRD_N = 4'd9;

  typedef struct packed {
    logic [3:0]  op;
    logic [7:0]  arg;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 42;
  localparam vec_t TBL [NV] = '{
    '{OP_WRD,   8'h0, 32'h0, 32'h0000_0004, 4'd2},  // R2 up = present & enable
    '{OP_WRD,   8'hC, 32'h0, 32'hFFFF_FFFC, 4'd8},  // R8 enable rebuilt
    '{OP_WRD,   8'h4, 32'h0, 32'h0,         4'd8},  // R8 nothing pending
    '{OP_WRD,   8'h8, 32'h0, 32'h0,         4'd3},  // R3 eject reads zero
    '{OP_GRD,   8'h0, 32'h0, 32'h0,         4'd12}, // R12 status clear
    '{OP_SCI,   8'h0, 32'h0, 32'h0,         4'd11}, // R11
    '{OP_PLUG,  8'd5, 32'h0, 32'h0,         4'd5},
    '{OP_WRD,   8'h0, 32'h0, 32'h0000_0024, 4'd5},  // R5 present set
    '{OP_GRD,   8'h0, 32'h0, 32'h2,         4'd5},  // R5 status bit 1
    '{OP_SCI,   8'h0, 32'h0, 32'h0,         4'd11}, // R11 not enabled
    '{OP_GWR,   8'h2, 32'h2, 32'h0,         4'd12},
    '{OP_GRD,   8'h2, 32'h0, 32'h2,         4'd12}, // R12 enable readback
    '{OP_SCI,   8'h0, 32'h0, 32'h1,         4'd11}, // R11 fires
    '{OP_GWR,   8'h0, 32'h0, 32'h0,         4'd12},
    '{OP_GRD,   8'h0, 32'h0, 32'h2,         4'd12}, // R12 zero write no effect
    '{OP_GWR,   8'h0, 32'hFD, 32'h0,        4'd12},
    '{OP_GRD,   8'h0, 32'h0, 32'h2,         4'd12}, // R12 other ones leave bit 1
    '{OP_GWR,   8'h0, 32'h2, 32'h0,         4'd12},
    '{OP_GRD,   8'h0, 32'h0, 32'h0,         4'd12}, // R12 cleared
    '{OP_SCI,   8'h0, 32'h0, 32'h0,         4'd11}, // R11 drops
    '{OP_COLD,  8'd9, 32'h0, 32'h0,         4'd7},
    '{OP_WRD,   8'h0, 32'h0, 32'h0000_0224, 4'd7},  // R7 present set
    '{OP_GRD,   8'h0, 32'h0, 32'h0,         4'd7},  // R7 no status
    '{OP_UNPLUG,8'd5, 32'h0, 32'h0,         4'd6},
    '{OP_WRD,   8'h4, 32'h0, 32'h0000_0020, 4'd6},  // R6 pending set
    '{OP_WRD,   8'h0, 32'h0, 32'h0000_0224, 4'd6},  // R6 present kept
    '{OP_GRD,   8'h0, 32'h0, 32'h2,         4'd6},  // R6 status bit 1
    '{OP_SCI,   8'h0, 32'h0, 32'h1,         4'd11}, // R11
    '{OP_UNPLUG,8'd9, 32'h0, 32'h0,         4'd6},
    '{OP_WRD,   8'h4, 32'h0, 32'h0000_0220, 4'd1},  // R1 pending map
    '{OP_WWR,   8'h8, 32'h0000_0220, 32'h0, 4'd4},
    '{OP_WRD,   8'h4, 32'h0, 32'h0000_0200, 4'd4},  // R4 lowest only
    '{OP_WRD,   8'h0, 32'h0, 32'h0000_0204, 4'd4},  // R4 present cleared
    '{OP_WWR_N, 8'h8, 32'h0000_0200, 32'h0, 4'd9},
    '{OP_WRD,   8'h4, 32'h0, 32'h0000_0200, 4'd9},  // R9 narrow write ignored
    '{OP_WRD_N, 8'h4, 32'h0, 32'h0,         4'd9},  // R9 narrow read zero
    '{OP_WWR,   8'h8, 32'h0, 32'h0,         4'd4},
    '{OP_WRD,   8'h4, 32'h0, 32'h0000_0200, 4'd4},  // R4 zero data no effect
    '{OP_WWR,   8'h8, 32'h8000_0200, 32'h0, 4'd4},
    '{OP_WRD,   8'h4, 32'h0, 32'h0,         4'd4},  // R4 slot 9 chosen
    '{OP_WRD,   8'h0, 32'h0, 32'h0000_0004, 4'd4},  // R4
    '{OP_WRD,   8'h1, 32'h0, 32'h0,         4'd1}   // R1 other offset
  };

  logic        clk, rst_n, plat_rst;
  logic        acc_valid, acc_write;
  logic [3:0]  acc_addr;
  logic [2:0]  acc_bytes;
  logic [31:0] acc_wdata, acc_rdata;
  logic        gpe_valid, gpe_write;
  logic [1:0]  gpe_addr;
  logic [7:0]  gpe_wdata, gpe_rdata;
  logic [1:0]  ev_kind;
  logic [4:0]  ev_slot;
  logic [31:0] nohp_mask, populated;
  logic        ready, sci;

  int nchk = 0;
  int nerr = 0;

  hp_slot_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .plat_rst(plat_rst),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .acc_bytes(acc_bytes), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .gpe_valid(gpe_valid), .gpe_write(gpe_write), .gpe_addr(gpe_addr),
    .gpe_wdata(gpe_wdata), .gpe_rdata(gpe_rdata),
    .ev_kind(ev_kind), .ev_slot(ev_slot),
    .nohp_mask(nohp_mask), .populated(populated),
    .ready(ready), .sci(sci)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ev(input logic [1:0] kind, input logic [4:0] slot);
    @(negedge clk);
    ev_kind = kind; ev_slot = slot;
    @(negedge clk);
    ev_kind = 2'd3;
  endtask

  task automatic wwr(input logic [3:0] a, input logic [31:0] d, input logic [2:0] nb);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d; acc_bytes = nb;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic wrd(input logic [3:0] a, input logic [2:0] nb, output logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a; acc_bytes = nb;
    #1 d = acc_rdata;
    acc_valid = 1'b0;
  endtask

  task automatic gwr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    gpe_valid = 1'b1; gpe_write = 1'b1; gpe_addr = a; gpe_wdata = d;
    @(negedge clk);
    gpe_valid = 1'b0; gpe_write = 1'b0;
  endtask

  task automatic grd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    gpe_valid = 1'b1; gpe_write = 1'b0; gpe_addr = a;
    #1 d = {24'h0, gpe_rdata};
    gpe_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    nerr++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int lows;
    rst_n = 1'b0; plat_rst = 1'b0;
    acc_valid = 1'b0; acc_write = 1'b0; acc_addr = '0; acc_bytes = 3'd4; acc_wdata = '0;
    gpe_valid = 1'b0; gpe_write = 1'b0; gpe_addr = '0; gpe_wdata = '0;
    ev_kind = 2'd3; ev_slot = '0;
    nohp_mask = 32'h0000_0003; populated = 32'h0000_0007;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    lows = 0;
    while (!ready && lows < 20) begin @(negedge clk); lows++; end
    chk("R8 ready after reset", {31'h0, ready}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = TBL[i];
      case (v.op)
        OP_COLD:   ev(2'd0, v.arg[4:0]);
        OP_PLUG:   ev(2'd1, v.arg[4:0]);
        OP_UNPLUG: ev(2'd2, v.arg[4:0]);
        OP_WWR:    wwr(v.arg[3:0], v.data, 3'd4);
        OP_WWR_N:  wwr(v.arg[3:0], v.data, 3'd2);
        OP_WRD: begin
          wrd(v.arg[3:0], 3'd4, rd);
          chk($sformatf("R%0d vec %0d", v.req, i), rd, v.exp);
        end
        OP_WRD_N: begin
          wrd(v.arg[3:0], 3'd1, rd);
          chk($sformatf("R%0d vec %0d", v.req, i), rd, v.exp);
        end
        OP_GWR:    gwr(v.arg[1:0], v.data[7:0]);
        OP_GRD: begin
          grd(v.arg[1:0], rd);
          chk($sformatf("R%0d vec %0d", v.req, i), rd, v.exp);
        end
        OP_SCI: begin
          @(negedge clk);
          chk($sformatf("R%0d vec %0d", v.req, i), {31'h0, sci}, v.exp);
        end
        default: ;
      endcase
    end

    // R4: the live non-hotpluggable mask keeps the present bit on eject
    nohp_mask = 32'h0000_0007;
    ev(2'd2, 5'd2);
    wwr(4'h8, 32'h0000_0004, 3'd4);
    wrd(4'h0, 3'd4, rd); chk("R4 nohp slot stays present", rd, 32'h0000_0004);
    wrd(4'h4, 3'd4, rd); chk("R4 nohp pending cleared", rd, 32'h0);
    nohp_mask = 32'h0000_0003;

    // R13: unplug and eject of one slot in the same cycle
    @(negedge clk);
    ev_kind = 2'd2; ev_slot = 5'd6;
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 4'h8; acc_bytes = 3'd4; acc_wdata = 32'h40;
    @(negedge clk);
    ev_kind = 2'd3; acc_valid = 1'b0; acc_write = 1'b0;
    wrd(4'h4, 3'd4, rd); chk("R13 pending kept", rd, 32'h0000_0040);
    wwr(4'h8, 32'h0000_0040, 3'd4);
    wrd(4'h4, 3'd4, rd); chk("R13 later eject", rd, 32'h0);

    // R12: an event beats a clear of the same status bit
    @(negedge clk);
    ev_kind = 2'd1; ev_slot = 5'd7;
    gpe_valid = 1'b1; gpe_write = 1'b1; gpe_addr = 2'd0; gpe_wdata = 8'h02;
    @(negedge clk);
    ev_kind = 2'd3; gpe_valid = 1'b0; gpe_write = 1'b0;
    grd(2'd0, rd); chk("R12 set wins over clear", rd, 32'h2);
    gwr(2'd0, 8'h02);
    grd(2'd0, rd); chk("R12 clear afterwards", rd, 32'h0);

    // R10: platform reset flushes three pending slots
    ev(2'd2, 5'd10);
    ev(2'd2, 5'd11);
    ev(2'd2, 5'd12);
    wrd(4'h4, 3'd4, rd); chk("R10 pending before flush", rd, 32'h0000_1C00);
    @(negedge clk);
    plat_rst = 1'b1;
    @(negedge clk);
    plat_rst = 1'b0;
    lows = 0;
    while (!ready && lows < 50) begin
      lows++;
      if (lows == 1) begin ev_kind = 2'd1; ev_slot = 5'd20; end
      @(negedge clk);
      if (lows == 1) ev_kind = 2'd3;
    end
    chk("R10 ready-low cycles", 32'(lows), 32'd5);
    wrd(4'h4, 3'd4, rd); chk("R10 pending empty", rd, 32'h0);
    wrd(4'h0, 3'd4, rd); chk("R10 present rebuilt, event ignored", rd, 32'h0000_0004);
    wrd(4'hC, 3'd4, rd); chk("R8 enable rebuilt", rd, 32'hFFFF_FFFC);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule